// File: doc/BRIEF.md
# Custom Instruction Sequencer

The sequencer sits beside a base processor's fetch stage. It hands control to a reconfigurable execution unit when the fetch program counter reaches the first instruction of a known hot basic block. A small fully associative table pairs each such block's start address with the index of the configuration that implements it. Software fills this table while the system is in training mode. While the system is in normal mode, every valid fetch address is compared against all entries in parallel.

On a hit in normal mode, the sequencer stalls the processor in the same cycle. In the next cycle it pulses a start strobe to the unit together with the stored configuration index. It then waits for the unit's completion strobe. The unit reports where execution continues, so the sequencer captures that address on the completion cycle. In the following cycle it raises a redirect toward the fetch stage, and this is also the last cycle of the stall. A mode change, or a table write, that arrives while a custom instruction is in flight has no effect until the sequencer is idle again.

Top module: `ciSequencer`

## Requirements
- R1: After reset, `stall`, `ruStart` and `redirect` are low and the table holds no valid entry, so no fetch address dispatches until an entry has been written.
- R2: In normal mode, a fetch address that matches no valid entry, or any address presented with `pcValid` low, leaves `stall` and `ruStart` low.
- R3: While `trainMode` is 1 (training), a fetch address that matches a valid entry never raises `stall` or `ruStart`.
- R4: A table write with `wrEn` high takes effect only while `trainMode` is 1 and the sequencer is idle. A write attempted in normal mode leaves the table unchanged.
- R5: In normal mode (`trainMode` 0), an idle cycle with `pcValid` high and a matching fetch address raises `stall` in that same cycle. In the next cycle `ruStart` is high for exactly one cycle, and `ruCfg` carries the matching entry's 4-bit index.
- R6: `stall` stays high in every cycle from the match through the cycle after `ruDone`, whatever the number of wait cycles (including `ruDone` in the first wait cycle), and it is low in the cycle after that.
- R7: In the cycle after `ruDone` is high in the wait state, `redirect` is high for one cycle and `redirectPc` equals the value `ruNextPc` had in the `ruDone` cycle.
- R8: A training write whose address equals that of a valid entry replaces that entry's configuration index and does not use a new slot.
- R9: A training write with a new address takes a free slot. Once all 16 slots are valid, a write with a new address is dropped, and that address never dispatches.
- R10: A change of `trainMode`, and any write, presented while a custom instruction is in flight has no effect until the sequencer returns to idle. From the first idle cycle on, the current `trainMode` applies.
- R11: While a custom instruction is in flight, a matching fetch address does not start another dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trainMode | input | 1 | 1 = training (table writes), 0 = normal (lookups) |
| wrEn | input | 1 | Table write request |
| wrAddr | input | 32 | Block start address to store |
| wrCfg | input | 4 | Configuration index to store |
| fetchPc | input | 32 | Processor fetch program counter |
| pcValid | input | 1 | `fetchPc` is valid this cycle |
| stall | output | 1 | Hold the processor pipeline |
| ruStart | output | 1 | One-cycle start strobe to the reconfigurable unit |
| ruCfg | output | 4 | Configuration index for the unit |
| ruDone | input | 1 | Unit completion strobe |
| ruNextPc | input | 32 | Continuation address supplied by the unit with `ruDone` |
| redirect | output | 1 | Resume fetch at `redirectPc` |
| redirectPc | output | 32 | Address at which the processor resumes |

## Verification
Fetch addresses are applied in several forms: misses, hits presented with `pcValid` low, and hits in each mode. Together these separate the lookup itself from the mode and qualifier gating. Dispatches are run with completion after one wait cycle and after several, which shows whether the stall window and the redirect timing depend on latency. Entries are overwritten, and the table is filled past capacity, so the index that a later dispatch carries shows whether a write replaced an entry, took a slot, or was dropped. Finally, a switch to training and a write are raised in the middle of a dispatch, which shows that both are deferred until the sequencer is idle.

// File: rtl/ciSeqPkg.sv
package ciSeqPkg;
  typedef enum logic [1:0] {
    IDLE      = 2'd0,
    DISPATCH  = 2'd1,
    WAIT_DONE = 2'd2,
    RESUME    = 2'd3
  } seqStateT;

  typedef struct packed {
    logic wrAllow;
    logic loadCfg;
    logic loadPc;
  } seqStrobeT;
endpackage

// File: rtl/ciSeqTable.sv
module ciSeqTable
  import ciSeqPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CFG_W   = 4,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CFG_W-1:0]  wrCfg,
  input  logic [ADDR_W-1:0] lookPc,
  input  logic [ADDR_W-1:0] nextPcIn,
  output logic              hit,
  output logic [CFG_W-1:0]  cfgOut,
  output logic [ADDR_W-1:0] pcOut
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] validQ;
  logic [ADDR_W-1:0]  addrQ [ENTRIES];
  logic [CFG_W-1:0]   cfgQ  [ENTRIES];
  logic [ENTRIES-1:0] lookMatch, wrMatch;

  logic               wrHit, freeAny;
  logic [IDX_W-1:0]   wrHitIdx, freeIdx;
  logic [CFG_W-1:0]   hitCfg;
  logic [CFG_W-1:0]   cfgLatchQ;
  logic [ADDR_W-1:0]  pcLatchQ;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign lookMatch[g] = validQ[g] && (addrQ[g] == lookPc);
    assign wrMatch[g]   = validQ[g] && (addrQ[g] == wrAddr);
  end

  always_comb begin
    hit = 1'b0;
    hitCfg = '0;
    wrHit = 1'b0;
    wrHitIdx = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hit && lookMatch[i]) begin
        hit = 1'b1;
        hitCfg = cfgQ[i];
      end
      if (!wrHit && wrMatch[i]) begin
        wrHit = 1'b1;
        wrHitIdx = IDX_W'(i);
      end
      if (!freeAny && !validQ[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.wrAllow && wrEn) begin
      if (wrHit) begin
        cfgQ[wrHitIdx] <= wrCfg;
      end else if (freeAny) begin
        validQ[freeIdx] <= 1'b1;
        addrQ[freeIdx]  <= wrAddr;
        cfgQ[freeIdx]   <= wrCfg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgLatchQ <= '0;
      pcLatchQ  <= '0;
    end else begin
      if (strobe.loadCfg) cfgLatchQ <= hitCfg;
      if (strobe.loadPc)  pcLatchQ  <= nextPcIn;
    end
  end

  assign cfgOut = cfgLatchQ;
  assign pcOut  = pcLatchQ;
endmodule

// File: rtl/ciSeqCtrl.sv
module ciSeqCtrl
  import ciSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      trainMode,
  input  logic      pcValid,
  input  logic      hit,
  input  logic      ruDone,
  output seqStrobeT strobe,
  output logic      stall,
  output logic      ruStart,
  output logic      redirect
);
  seqStateT stateQ, stateD;
  logic     startReq;

  assign startReq = (stateQ == IDLE) && !trainMode && pcValid && hit;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      IDLE:      if (startReq) stateD = DISPATCH;
      DISPATCH:  stateD = WAIT_DONE;
      WAIT_DONE: if (ruDone) stateD = RESUME;
      RESUME:    stateD = IDLE;
      default:   stateD = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.wrAllow = (stateQ == IDLE) && trainMode;
    strobe.loadCfg = startReq;
    strobe.loadPc  = (stateQ == WAIT_DONE) && ruDone;
  end

  assign stall    = (stateQ != IDLE) || startReq;
  assign ruStart  = (stateQ == DISPATCH);
  assign redirect = (stateQ == RESUME);
endmodule

// File: rtl/ciSequencer.sv
module ciSequencer
  import ciSeqPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CFG_W   = 4,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trainMode,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CFG_W-1:0]  wrCfg,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              pcValid,
  output logic              stall,
  output logic              ruStart,
  output logic [CFG_W-1:0]  ruCfg,
  input  logic              ruDone,
  input  logic [ADDR_W-1:0] ruNextPc,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectPc
);
  seqStrobeT strobe;
  logic      hit;

  ciSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .trainMode(trainMode), .pcValid(pcValid),
    .hit(hit), .ruDone(ruDone), .strobe(strobe), .stall(stall),
    .ruStart(ruStart), .redirect(redirect)
  );

  ciSeqTable #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrCfg(wrCfg), .lookPc(fetchPc), .nextPcIn(ruNextPc), .hit(hit),
    .cfgOut(ruCfg), .pcOut(redirectPc)
  );
endmodule

// File: rtl/ciSequencer_chk.sv
module ciSequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              trainMode,
  input logic              stall,
  input logic              ruStart,
  input logic              ruDone,
  input logic [ADDR_W-1:0] ruNextPc,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirectPc
);
  // R5: the start strobe lasts one cycle and is always covered by the stall
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    ruStart |=> !ruStart);
  p_start_stalled_r5: assert property (@(posedge clk) disable iff (!rstN)
    ruStart |-> stall);

  // R3: a dispatch only follows a normal-mode cycle
  p_no_train_dispatch_r3: assert property (@(posedge clk) disable iff (!rstN)
    ruStart |-> !$past(trainMode));

  // R6: once raised, the stall is held until the redirect cycle
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !redirect) |=> stall);

  // R7: the redirect follows completion and carries the unit's address
  p_redirect_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> $past(ruDone));
  p_redirect_pc_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (redirectPc == $past(ruNextPc)));
  p_redirect_stalled_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> stall);
endmodule

bind ciSequencer ciSequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .trainMode(trainMode), .stall(stall),
  .ruStart(ruStart), .ruDone(ruDone), .ruNextPc(ruNextPc),
  .redirect(redirect), .redirectPc(redirectPc)
);

// File: tb/ciSequencer_bench.sv
module ciSequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trainMode = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrAddr = '0;
  logic [3:0]  wrCfg = '0;
  logic [31:0] fetchPc = '0;
  logic        pcValid = 1'b0;
  logic        ruDone = 1'b0;
  logic [31:0] ruNextPc = '0;
  logic        stall, ruStart, redirect;
  logic [3:0]  ruCfg;
  logic [31:0] redirectPc;

  int checks = 0;
  int failures = 0;

  // reference model state
  int          mState = 0;
  bit          mv [16];
  logic [31:0] ma [16];
  logic [3:0]  mc [16];
  logic [3:0]  mCfg = '0;
  logic [31:0] mPc = '0;

  always #2.5 clk = ~clk;

  ciSequencer u_ciSequencer (
    .clk(clk), .rstN(rstN), .trainMode(trainMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrCfg(wrCfg), .fetchPc(fetchPc), .pcValid(pcValid),
    .stall(stall), .ruStart(ruStart), .ruCfg(ruCfg), .ruDone(ruDone),
    .ruNextPc(ruNextPc), .redirect(redirect), .redirectPc(redirectPc)
  );

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL all: watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int modelHit();
    for (int i = 0; i < 16; i++)
      if (mv[i] && ma[i] == fetchPc) return i;
    return -1;
  endfunction

  // inputs are already set; compare, then advance the model over one edge
  task automatic step(input string tag);
    int h;
    bit expStall;
    #1;
    h = modelHit();
    expStall = (mState != 0) || (!trainMode && pcValid && h >= 0);
    chk(tag, "stall", {31'd0, stall}, {31'd0, expStall});
    chk(tag, "ruStart", {31'd0, ruStart}, {31'd0, mState == 1});
    chk(tag, "redirect", {31'd0, redirect}, {31'd0, mState == 3});
    if (mState == 1) chk(tag, "ruCfg", {28'd0, ruCfg}, {28'd0, mCfg});
    if (mState == 3) chk(tag, "redirectPc", redirectPc, mPc);
    @(posedge clk);
    case (mState)
      0: begin
        if (trainMode && wrEn) begin
          int w = -1;
          for (int i = 0; i < 16; i++) if (w < 0 && mv[i] && ma[i] == wrAddr) w = i;
          if (w >= 0) mc[w] = wrCfg;
          else begin
            for (int i = 0; i < 16; i++) if (w < 0 && !mv[i]) w = i;
            if (w >= 0) begin mv[w] = 1; ma[w] = wrAddr; mc[w] = wrCfg; end
          end
        end else if (!trainMode && pcValid && h >= 0) begin
          mCfg = mc[h];
          mState = 1;
        end
      end
      1: mState = 2;
      2: if (ruDone) begin mPc = ruNextPc; mState = 3; end
      default: mState = 0;
    endcase
    @(negedge clk);
  endtask

  task automatic writeEntry(input logic [31:0] a, input logic [3:0] c, input string tag);
    wrEn = 1; wrAddr = a; wrCfg = c;
    step(tag);
    wrEn = 0;
  endtask

  task automatic fetch(input logic [31:0] pc, input bit v, input string tag);
    fetchPc = pc; pcValid = v;
    step(tag);
  endtask

  // match pc, wait waitN cycles, complete with nextPc, resume
  task automatic runCi(input logic [31:0] pc, input int waitN,
                       input logic [31:0] nextPc, input string tag);
    fetch(pc, 1, tag);
    fetchPc = pc + 4;
    step(tag);
    for (int i = 0; i < waitN; i++) step(tag);
    ruDone = 1; ruNextPc = nextPc;
    step(tag);
    ruDone = 0; ruNextPc = 32'hdead_beef;
    step(tag);
    fetchPc = nextPc;
    step(tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mv[i] = 0; ma[i] = '0; mc[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: quiet after reset, empty table
    step("R1");
    trainMode = 0;
    fetch(32'h0000_1000, 1, "R1");
    fetch(32'h0000_0000, 1, "R1");

    // training fills
    trainMode = 1;
    writeEntry(32'h0000_0400, 4'd3, "R9");
    writeEntry(32'h0000_0800, 4'd5, "R9");
    fetch(32'h0000_0400, 1, "R3");
    fetch(32'h0000_0800, 1, "R3");

    // normal mode misses and qualifier
    trainMode = 0;
    fetch(32'h0000_0404, 1, "R2");
    fetch(32'h0000_0400, 0, "R2");

    // writes in normal mode ignored
    writeEntry(32'h0000_0c00, 4'd7, "R4");
    fetch(32'h0000_0c00, 1, "R4");

    // dispatch with several wait cycles, matching pc while busy
    fetch(32'h0000_0400, 1, "R5");
    fetchPc = 32'h0000_0800;
    step("R11");
    step("R11");
    step("R6");
    ruDone = 1; ruNextPc = 32'h0000_0440;
    step("R7");
    ruDone = 0;
    fetchPc = 32'h0000_0440;
    step("R7");
    step("R6");

    // completion in the first wait cycle
    runCi(32'h0000_0800, 0, 32'h0000_0880, "R6");

    // overwrite an existing entry
    trainMode = 1;
    writeEntry(32'h0000_0400, 4'd9, "R8");
    trainMode = 0;
    runCi(32'h0000_0400, 2, 32'h0000_0480, "R8");

    // fill the table, then overflow
    trainMode = 1;
    for (int i = 0; i < 14; i++)
      writeEntry(32'h0000_2000 + 32'(i * 16), 4'(i), "R9");
    writeEntry(32'h0000_9000, 4'd15, "R9");
    trainMode = 0;
    fetch(32'h0000_9000, 1, "R9");
    runCi(32'h0000_20d0, 1, 32'h0000_2100, "R9");

    // mode change and write while in flight
    fetch(32'h0000_0800, 1, "R10");
    trainMode = 1; fetchPc = 32'h0000_0804;
    wrEn = 1; wrAddr = 32'h0000_0800; wrCfg = 4'd1;
    step("R10");
    step("R10");
    ruDone = 1; ruNextPc = 32'h0000_0900;
    step("R10");
    ruDone = 0; wrEn = 0;
    step("R10");
    fetch(32'h0000_0800, 1, "R10");
    trainMode = 0;
    runCi(32'h0000_0800, 1, 32'h0000_0910, "R10");
    trainMode = 1;
    writeEntry(32'h0000_0800, 4'd2, "R10");
    trainMode = 0;
    runCi(32'h0000_0800, 1, 32'h0000_0920, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule